// File: doc/BRIEF.md
# Register File Bank Power Gating Controller

This block decides, cycle by cycle, which banks of a banked physical register file need power. It listens to the rename stage, which hands out physical registers, and to the commit stage, which gives them back. A bank powers up as soon as a register inside it is handed out. It powers down once none of its registers is still in use.

Inside, the block keeps one busy bit per physical register and one live-register counter per bank. It drives one power enable per bank. Each cycle it accepts up to two allocation requests and two release requests, each carrying a register index. Each request is judged against the busy map as it stood before the clock edge. A request that makes no sense is dropped and sets a sticky error flag. Such requests are an allocation of a register already in use, a release of a register already free, or an index past the last register. The register storage arrays and the policy that picks free registers live elsewhere.

Top module: `regfile_bank_gate`

## Requirements
- R1: After a synchronous reset every register is free, every bank enable is low and the error flag is low.
- R2: With default parameters there are 112 registers in 7 banks of 16. Register i belongs to bank i/16, and each bank's enable depends only on its own registers.
- R3: An accepted allocation into a bank with no live registers raises that bank's enable combinationally in the same cycle as the request. The enable stays high afterwards while the register is live.
- R4: A bank's enable stays high while any of its registers is live. It drops in the cycle after the clock edge that releases its last live register.
- R5: Two allocations and two releases offered in one cycle, all legal, all take effect at the same clock edge.
- R6: An accepted allocation and an accepted release hitting the same bank in one cycle never cause that bank's enable to drop.
- R7: Allocating a busy register, releasing a free register, or using an index of 112 or above has no effect on any register or enable. It sets the error flag at the next clock edge.
- R8: In one cycle, a second request of the same kind to the same index on port 1 is rejected as an error while port 0 is accepted. An allocation and a release of the same index in one cycle are each judged against the map before the edge, so exactly one of them takes effect.
- R9: Once set, the error flag stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 2 | Per-port allocation request valid |
| alloc_idx | input | 2x7 | Per-port register index to allocate |
| free_valid | input | 2 | Per-port release request valid |
| free_idx | input | 2x7 | Per-port register index to release |
| bank_en | output | 7 | Per-bank power enable |
| err_sticky | output | 1 | Sticky illegal-request flag |

## Verification
A wake-up by allocation and a sleep by release can hit the same bank in one cycle. Allocation and release can also target the very same register in one cycle. The bench provokes both with directed pairs first: an allocation and a release into bank 1 together, then the same index on both sides. A long pseudo-random phase then draws indices from a narrow range so that these overlaps occur often. A behavioural model predicts each enable and the error flag. It judges every request against the map as it stood before the edge, and it is compared against the outputs on every clock.

// File: rtl/rfbg_pkg.sv
// Package: shared defaults for the register-file bank gating block.
// Assumes the register count is a whole multiple of the bank size.
package rfbg_pkg;
    localparam int DEF_NUM_REGS  = 112;
    localparam int DEF_BANK_SIZE = 16;
    localparam int DEF_PORTS     = 2;
endpackage

// File: rtl/rfbg_req_check.sv
// Request checker: decides which allocation and release requests are legal.
// Every request is judged against the busy map before the clock edge; a
// port also loses to a lower port carrying the same kind and same index.
// Assumes nothing about the order in which rename and commit present work.
module rfbg_req_check #(
    parameter int NUM_REGS = 112,
    parameter int PORTS    = 2,
    parameter int IDX_W    = 7
) (
    input  logic [NUM_REGS-1:0]         busy,
    input  logic [PORTS-1:0]            a_vld,
    input  logic [PORTS-1:0][IDX_W-1:0] a_idx,
    input  logic [PORTS-1:0]            f_vld,
    input  logic [PORTS-1:0][IDX_W-1:0] f_idx,
    output logic [PORTS-1:0]            a_ok,
    output logic [PORTS-1:0]            f_ok,
    output logic                        req_err
);
    // Judge every port of both kinds; any valid but rejected port is an error.
    always_comb begin
        logic legal;
        a_ok    = '0;
        f_ok    = '0;
        req_err = 1'b0;
        for (int p = 0; p < PORTS; p++) begin
            legal = (int'(a_idx[p]) < NUM_REGS) && !busy[a_idx[p]];
            for (int q = 0; q < p; q++)
                if (a_vld[q] && a_idx[q] == a_idx[p]) legal = 1'b0;
            a_ok[p] = a_vld[p] && legal;
            if (a_vld[p] && !legal) req_err = 1'b1;

            legal = (int'(f_idx[p]) < NUM_REGS) && busy[f_idx[p]];
            for (int q = 0; q < p; q++)
                if (f_vld[q] && f_idx[q] == f_idx[p]) legal = 1'b0;
            f_ok[p] = f_vld[p] && legal;
            if (f_vld[p] && !legal) req_err = 1'b1;
        end
    end
endmodule

// File: rtl/rfbg_busy_map.sv
// Busy map: one bit per physical register, set on accepted allocation and
// cleared on accepted release. Assumes accepted requests never set and
// clear the same bit in one cycle (the request checker guarantees it).
module rfbg_busy_map #(
    parameter int NUM_REGS = 112,
    parameter int PORTS    = 2,
    parameter int IDX_W    = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [PORTS-1:0]            a_ok,
    input  logic [PORTS-1:0][IDX_W-1:0] a_idx,
    input  logic [PORTS-1:0]            f_ok,
    input  logic [PORTS-1:0][IDX_W-1:0] f_idx,
    output logic [NUM_REGS-1:0]         busy
);
    logic [NUM_REGS-1:0] set_m;
    logic [NUM_REGS-1:0] clr_m;

    // Turn accepted requests into set and clear masks.
    always_comb begin
        set_m = '0;
        clr_m = '0;
        for (int p = 0; p < PORTS; p++) begin
            if (a_ok[p]) set_m[a_idx[p]] = 1'b1;
            if (f_ok[p]) clr_m[f_idx[p]] = 1'b1;
        end
    end

    // Hold the busy bits.
    always_ff @(posedge clk) begin
        if (!rst_n) busy <= '0;
        else        busy <= (busy | set_m) & ~clr_m;
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_chk
        // R5: each accepted allocation is visible in the map after the edge.
        a_r5_alloc_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
            a_ok[p] |=> busy[$past(a_idx[p])]);
        // R5: each accepted release is visible in the map after the edge.
        a_r5_free_clears_bit: assert property (@(posedge clk) disable iff (!rst_n)
            f_ok[p] |=> !busy[$past(f_idx[p])]);
    end
endmodule

// File: rtl/rfbg_bank_counter.sv
// Bank counter: live-register count and power enable for one bank.
// The enable rises in the same cycle as a waking allocation and falls once
// the count has reached zero. Assumes PORTS does not exceed BANK_SIZE.
module rfbg_bank_counter #(
    parameter int NUM_REGS  = 112,
    parameter int BANK_SIZE = 16,
    parameter int PORTS     = 2,
    parameter int IDX_W     = 7,
    parameter int BANK_ID   = 0,
    localparam int CNT_W    = $clog2(BANK_SIZE + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [PORTS-1:0]            a_ok,
    input  logic [PORTS-1:0][IDX_W-1:0] a_idx,
    input  logic [PORTS-1:0]            f_ok,
    input  logic [PORTS-1:0][IDX_W-1:0] f_idx,
    output logic [CNT_W-1:0]            live_cnt,
    output logic                        bank_en
);
    logic [CNT_W-1:0] inc;
    logic [CNT_W-1:0] dec;

    // Count accepted requests that fall into this bank.
    always_comb begin
        inc = '0;
        dec = '0;
        for (int p = 0; p < PORTS; p++) begin
            if (a_ok[p] && (int'(a_idx[p]) / BANK_SIZE) == BANK_ID) inc = inc + 1'b1;
            if (f_ok[p] && (int'(f_idx[p]) / BANK_SIZE) == BANK_ID) dec = dec + 1'b1;
        end
    end

    // Track the number of live registers in the bank.
    always_ff @(posedge clk) begin
        if (!rst_n) live_cnt <= '0;
        else        live_cnt <= live_cnt + inc - dec;
    end

    // Power while anything lives here or an allocation is arriving now.
    assign bank_en = (live_cnt != '0) || (inc != '0);

    // R2: a bank never holds more live registers than it has.
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(live_cnt) <= BANK_SIZE);
    // R4: the enable only falls after a release into this bank.
    a_r4_fall_needs_free: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bank_en) |-> $past(dec != '0));
    // R6: an accepted allocation keeps the bank powered across the edge.
    a_r6_alloc_keeps_on: assert property (@(posedge clk) disable iff (!rst_n)
        (inc != '0) |=> bank_en);
endmodule

// File: rtl/regfile_bank_gate.sv
// Top: power gating controller for a banked physical register file.
// Checks requests, keeps the busy map and per-bank counters, and holds a
// sticky error flag. Assumes NUM_REGS is a multiple of BANK_SIZE.
module regfile_bank_gate #(
    parameter int NUM_REGS   = rfbg_pkg::DEF_NUM_REGS,
    parameter int BANK_SIZE  = rfbg_pkg::DEF_BANK_SIZE,
    parameter int PORTS      = rfbg_pkg::DEF_PORTS,
    localparam int NUM_BANKS = NUM_REGS / BANK_SIZE,
    localparam int IDX_W     = $clog2(NUM_REGS),
    localparam int CNT_W     = $clog2(BANK_SIZE + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [PORTS-1:0]            alloc_valid,
    input  logic [PORTS-1:0][IDX_W-1:0] alloc_idx,
    input  logic [PORTS-1:0]            free_valid,
    input  logic [PORTS-1:0][IDX_W-1:0] free_idx,
    output logic [NUM_BANKS-1:0]        bank_en,
    output logic                        err_sticky
);
    logic [NUM_REGS-1:0]              busy;
    logic [PORTS-1:0]                 a_ok;
    logic [PORTS-1:0]                 f_ok;
    logic                             req_err;
    logic [NUM_BANKS-1:0][CNT_W-1:0]  live_cnt;

    rfbg_req_check #(.NUM_REGS(NUM_REGS), .PORTS(PORTS), .IDX_W(IDX_W)) u_check (
        .busy(busy), .a_vld(alloc_valid), .a_idx(alloc_idx),
        .f_vld(free_valid), .f_idx(free_idx),
        .a_ok(a_ok), .f_ok(f_ok), .req_err(req_err));

    rfbg_busy_map #(.NUM_REGS(NUM_REGS), .PORTS(PORTS), .IDX_W(IDX_W)) u_map (
        .clk(clk), .rst_n(rst_n), .a_ok(a_ok), .a_idx(alloc_idx),
        .f_ok(f_ok), .f_idx(free_idx), .busy(busy));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        rfbg_bank_counter #(.NUM_REGS(NUM_REGS), .BANK_SIZE(BANK_SIZE), .PORTS(PORTS),
                            .IDX_W(IDX_W), .BANK_ID(b)) u_cnt (
            .clk(clk), .rst_n(rst_n), .a_ok(a_ok), .a_idx(alloc_idx),
            .f_ok(f_ok), .f_idx(free_idx),
            .live_cnt(live_cnt[b]), .bank_en(bank_en[b]));

        // R2: the bank counter agrees with the busy bits of its own slice.
        a_r2_cnt_matches_map: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(busy[b*BANK_SIZE +: BANK_SIZE]) == int'(live_cnt[b]));
    end

    // Latch any rejected request until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) err_sticky <= 1'b0;
        else        err_sticky <= err_sticky | req_err;
    end

    // R9: the error flag never clears outside reset.
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err_sticky) |-> err_sticky);
    // R7: the flag only rises after a rejected request.
    a_r7_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_sticky) |-> $past(req_err));
endmodule

// File: tb/regfile_bank_gate_tb.sv
// Bench: behavioural reference model compared with the outputs every clock.
module regfile_bank_gate_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 112;
    localparam int BSZ  = 16;
    localparam int NB   = 7;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      alloc_valid = '0;
    logic [1:0][6:0] alloc_idx = '0;
    logic [1:0]      free_valid = '0;
    logic [1:0][6:0] free_idx = '0;
    logic [NB-1:0]   bank_en;
    logic            err_sticky;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 0;
    bit  m_busy [NREG];
    bit  m_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    regfile_bank_gate u_dut (
        .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_idx(alloc_idx),
        .free_valid(free_valid), .free_idx(free_idx),
        .bank_en(bank_en), .err_sticky(err_sticky));

    task automatic check(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; alloc_valid = '0; free_valid = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        foreach (m_busy[i]) m_busy[i] = 0;
        m_err = 0;
    endtask

    // One cycle: drive, predict, compare, then advance the model.
    task automatic step(string tag, bit av0, int ai0, bit av1, int ai1,
                        bit fv0, int fi0, bit fv1, int fi1);
        int ai[2]; int fi[2]; bit av[2]; bit fv[2];
        bit aacc[2]; bit facc[2]; bit bad;
        int exp_en;
        @(negedge clk);
        av[0] = av0; av[1] = av1; fv[0] = fv0; fv[1] = fv1;
        ai[0] = ai0; ai[1] = ai1; fi[0] = fi0; fi[1] = fi1;
        alloc_valid = {av1, av0}; free_valid = {fv1, fv0};
        alloc_idx[0] = 7'(ai0); alloc_idx[1] = 7'(ai1);
        free_idx[0]  = 7'(fi0); free_idx[1]  = 7'(fi1);
        bad = 0;
        for (int p = 0; p < 2; p++) begin
            aacc[p] = av[p] && ai[p] < NREG;
            if (aacc[p] && m_busy[ai[p]]) aacc[p] = 0;
            if (p == 1 && av[0] && ai[0] == ai[1]) aacc[p] = 0;
            if (av[p] && !aacc[p]) bad = 1;
            facc[p] = fv[p] && fi[p] < NREG;
            if (facc[p] && !m_busy[fi[p]]) facc[p] = 0;
            if (p == 1 && fv[0] && fi[0] == fi[1]) facc[p] = 0;
            if (fv[p] && !facc[p]) bad = 1;
        end
        exp_en = 0;
        for (int r = 0; r < NREG; r++)
            if (m_busy[r]) exp_en |= 1 << (r / BSZ);
        for (int p = 0; p < 2; p++)
            if (aacc[p]) exp_en |= 1 << (ai[p] / BSZ);
        #1;
        check(tag, "bank_en", int'(bank_en), exp_en);
        check(tag, "err_sticky", int'(err_sticky), int'(m_err));
        @(posedge clk);
        for (int p = 0; p < 2; p++) begin
            if (aacc[p]) m_busy[ai[p]] = 1;
            if (facc[p]) m_busy[fi[p]] = 0;
        end
        if (bad) m_err = 1;
    endtask

    task automatic idle(string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        idle("R1");                                   // all off, no error
        step("R3", 1, 5, 0, 0, 0, 0, 0, 0);           // bank0 wakes same cycle
        idle("R3");
        step("R5", 1, 16, 1, 111, 0, 0, 0, 0);        // banks 1 and 6 together
        step("R2", 1, 40, 0, 0, 0, 0, 0, 0);          // bank 2 only
        step("R4", 0, 0, 0, 0, 1, 5, 0, 0);           // last of bank0 released
        idle("R4");                                   // bank0 now off
        step("R6", 1, 17, 0, 0, 1, 16, 0, 0);         // same bank, net zero
        idle("R6");
        step("R5", 1, 80, 1, 81, 1, 40, 1, 111);      // two and two
        idle("R5");
        step("R7", 0, 0, 0, 0, 1, 16, 0, 0);          // release of free reg
        idle("R7");
        step("R9", 0, 0, 0, 0, 0, 0, 0, 0);
        do_reset();
        idle("R1");
        step("R7", 1, 120, 0, 0, 0, 0, 0, 0);         // index out of range
        idle("R7");
        do_reset();
        step("R3", 1, 33, 0, 0, 0, 0, 0, 0);
        step("R7", 1, 33, 0, 0, 0, 0, 0, 0);          // alloc of busy reg
        idle("R7");
        do_reset();
        step("R8", 1, 50, 1, 50, 0, 0, 0, 0);         // duplicate alloc
        idle("R8");
        do_reset();
        step("R8", 1, 60, 1, 61, 0, 0, 0, 0);
        step("R8", 0, 0, 0, 0, 1, 60, 1, 60);         // duplicate release
        step("R8", 1, 61, 0, 0, 1, 61, 0, 0);         // same idx both kinds
        step("R8", 1, 62, 0, 0, 1, 62, 0, 0);
        idle("R8");
        idle("R9");
        for (int round = 0; round < 4; round++) begin
            do_reset();
            for (int c = 0; c < 1500; c++) begin
                int lim;
                lim = (round == 3) ? 127 : 36;
                step("R6", 1'($urandom_range(0, 1)), int'($urandom_range(0, lim)),
                           1'($urandom_range(0, 1)), int'($urandom_range(0, lim)),
                           1'($urandom_range(0, 1)), int'($urandom_range(0, lim)),
                           1'($urandom_range(0, 1)), int'($urandom_range(0, lim)));
            end
        end
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule